// File: doc/BRIEF.md
# Serial Key Code Responder

This block models the identification side of a keyed access token. It holds a fixed binary code of four bits. It waits until a host raises a request line, and then plays the code back on a single serial data pin, one bit per clock. The least significant bit goes first. The default code is 4'b1011, so the pin carries 1, 1, 0, 1 on four consecutive cycles. After the last bit the block falls back to waiting.

The request line is sampled only while the block is waiting. Once a transmission has begun it always runs to completion, whatever the request does. If the host holds the request high, the block returns to waiting for one cycle after each transmission and then starts the next one. A synchronous reset aborts any transmission in progress.

Top module: `serial_key_responder`

## Requirements
- R1: While reset is high at a rising clock edge, the block enters the waiting state, and key_dout is 0 in the cycle after that edge.
- R2: While waiting with host_req low, key_dout stays 0 and the block stays in the waiting state.
- R3: If host_req is high at a clock edge while the block is waiting, key_dout carries code bit 0 (the least significant bit) in the very next cycle.
- R4: A transmission presents the code bits in order from bit 0 to bit 3, one bit per cycle. With the default code 4'b1011 the pin carries 1, 1, 0, 1.
- R5: host_req has no effect while a transmission is in progress. Neither the bit sequence nor its length changes.
- R6: After code bit 3 the block spends exactly one cycle waiting, with key_dout at 0. If host_req is high in that cycle, a new transmission starts in the following cycle.
- R7: A reset asserted in the middle of a transmission ends the transmission, and key_dout returns to 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Host asks for the key code; sampled only while waiting |
| key_dout | output | 1 | Serial code bit, least significant bit first; 0 while waiting |

## Verification
The hardest situation to produce is the boundary at the end of a transmission. Here a request that was held high through the last bit must be honoured only after the single waiting cycle, and a request that drops during that cycle must produce nothing. The stimulus holds host_req high across several whole transmissions, and it also releases the request on the waiting cycle itself. It toggles the request in the middle of a transmission and asserts reset on an inner bit. A queue-based reference model is compared against the pin on every clock.

// File: rtl/key_resp_pkg.sv
package key_resp_pkg;

    typedef enum logic {
        KR_WAIT = 1'b0,
        KR_SEND = 1'b1
    } kr_mode_e;

    localparam int unsigned KR_DEF_BITS = 4;
    localparam logic [KR_DEF_BITS-1:0] KR_DEF_CODE = 4'b1011;

endpackage

// File: rtl/key_seq_ctrl.sv
module key_seq_ctrl
    import key_resp_pkg::*;
#(
    parameter int unsigned NBITS = 4,
    localparam int unsigned IW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_i,
    output logic          send_o,
    output logic [IW-1:0] idx_o
);

    localparam logic [IW-1:0] LAST_IDX = IW'(NBITS - 1);

    typedef struct packed {
        kr_mode_e      mode;
        logic [IW-1:0] idx;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.mode)
            KR_WAIT: begin
                ctl_d.idx = '0;
                if (req_i) begin
                    ctl_d.mode = KR_SEND;
                end
            end
            KR_SEND: begin
                if (ctl_q.idx == LAST_IDX) begin
                    ctl_d.mode = KR_WAIT;
                    ctl_d.idx  = '0;
                end else begin
                    ctl_d.idx = ctl_q.idx + 1'b1;
                end
            end
            default: begin
                ctl_d.mode = KR_WAIT;
                ctl_d.idx  = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.mode <= KR_WAIT;
            ctl_q.idx  <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign send_o = (ctl_q.mode == KR_SEND);
    assign idx_o  = ctl_q.idx;

    // R2: waiting without a request keeps waiting
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!send_o && !req_i) |=> !send_o);

    // R3: request while waiting starts at bit 0
    assert_start_bit0_R3: assert property (@(posedge clk) disable iff (rst)
        (!send_o && req_i) |=> (send_o && idx_o == '0));

    // R4, R5: inner bits advance by one regardless of the request
    assert_step_ignores_req_R5: assert property (@(posedge clk) disable iff (rst)
        (send_o && idx_o != LAST_IDX) |=> (send_o && idx_o == $past(idx_o) + 1'b1));

    // R6: the last bit is followed by a waiting cycle
    assert_back_to_wait_R6: assert property (@(posedge clk) disable iff (rst)
        (send_o && idx_o == LAST_IDX) |=> !send_o);

endmodule

// File: rtl/key_bit_sel.sv
module key_bit_sel #(
    parameter int unsigned NBITS = 4,
    parameter logic [NBITS-1:0] CODE = 4'b1011,
    localparam int unsigned IW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
    input  logic          send_i,
    input  logic [IW-1:0] idx_i,
    output logic          bit_o
);

    logic [NBITS-1:0] onehot;
    logic             picked;

    genvar g;
    generate
        for (g = 0; g < NBITS; g++) begin : g_dec
            assign onehot[g] = (idx_i == IW'(g));
        end
    endgenerate

    assign picked = |(onehot & CODE);
    assign bit_o  = send_i & picked;

endmodule

// File: rtl/serial_key_responder.sv
module serial_key_responder
    import key_resp_pkg::*;
#(
    parameter int unsigned NBITS = KR_DEF_BITS,
    parameter logic [NBITS-1:0] KEY_CODE = KR_DEF_CODE
) (
    input  logic clk,
    input  logic rst,
    input  logic host_req,
    output logic key_dout
);

    localparam int unsigned IW = (NBITS > 1) ? $clog2(NBITS) : 1;

    logic          send;
    logic [IW-1:0] idx;

    key_seq_ctrl #(.NBITS(NBITS)) u_ctl (
        .clk    (clk),
        .rst    (rst),
        .req_i  (host_req),
        .send_o (send),
        .idx_o  (idx)
    );

    key_bit_sel #(.NBITS(NBITS), .CODE(KEY_CODE)) u_sel (
        .send_i (send),
        .idx_i  (idx),
        .bit_o  (key_dout)
    );

    // R2: the pin is low whenever the controller waits
    assert_idle_low_R2: assert property (@(posedge clk) disable iff (rst)
        !send |-> !key_dout);

    // R3, R4: first bit after a request is code bit 0
    assert_first_bit_R4: assert property (@(posedge clk) disable iff (rst)
        (!send && host_req) |=> (key_dout == KEY_CODE[0]));

endmodule

// File: tb/sim_serial_key_responder.sv
module sim_serial_key_responder;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_req = 1'b0;
    logic key_dout;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string cur_tag = "R1";

    localparam logic [3:0] CODE = 4'b1011;

    always #4 clk = ~clk;

    serial_key_responder u0 (
        .clk      (clk),
        .rst      (rst),
        .host_req (host_req),
        .key_dout (key_dout)
    );

    // Reference model: a queue of bits still to be shown on the pin
    bit exp_q[$];

    always @(posedge clk) begin
        if (rst) begin
            exp_q.delete();
        end else if (exp_q.size() != 0) begin
            void'(exp_q.pop_front());
        end else if (host_req) begin
            for (int i = 0; i < 4; i++) exp_q.push_back(CODE[i]);
        end
    end

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s key_dout actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare on every clock, away from the edge
    always @(negedge clk) begin
        if (!finished) begin
            logic e;
            string t;
            e = (exp_q.size() != 0) ? exp_q[0] : 1'b0;
            if (cur_tag != "") t = cur_tag;
            else if (exp_q.size() == 0) t = "R2";
            else if (exp_q.size() == 4) t = "R3";
            else t = "R4";
            check(t, key_dout, e);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_tag = "R1";
        cyc(3);
        rst = 1'b0;
        cur_tag = "";
        // R2: idle with no request
        cyc(5);
        // R3, R4: single request pulse
        host_req = 1'b1;
        cyc(1);
        host_req = 1'b0;
        cyc(6);
        // R5: request toggling during a transmission
        host_req = 1'b1;
        cyc(1);
        cur_tag = "R5";
        host_req = 1'b0; cyc(1);
        host_req = 1'b1; cyc(1);
        host_req = 1'b0; cyc(3);
        // R6: request held high over back-to-back transmissions
        cur_tag = "R6";
        host_req = 1'b1;
        cyc(16);
        // R6: request dropped on the waiting cycle itself
        host_req = 1'b0;
        cyc(6);
        host_req = 1'b1;
        cyc(5);
        host_req = 1'b0;
        cyc(3);
        // R7: reset in the middle of a transmission
        cur_tag = "R7";
        host_req = 1'b1;
        cyc(3);
        host_req = 1'b0;
        rst = 1'b1;
        cyc(1);
        rst = 1'b0;
        cyc(4);
        // R1: a longer reset with the request held high
        cur_tag = "R1";
        host_req = 1'b1;
        rst = 1'b1;
        cyc(3);
        rst = 1'b0;
        cur_tag = "";
        cyc(10);
        host_req = 1'b0;
        cyc(6);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule